// File: doc/BRIEF.md
# 1-Wire ROM Command Handler

This block sits on top of a 1-Wire bit layer inside a slave device. After the bit layer reports a bus reset, the block collects the function command byte, least significant bit first. It then runs ROM selection against a fixed 64-bit device identifier that is set by a parameter. Two commands are recognised: Match ROM (0x55) and Search ROM (0xF0). Any other byte parks the device until the next bus reset.

The bit layer gives the block a strobe at the end of every time slot, together with the line value sampled in that slot. The block tells the bit layer when it must drive the line in the next slot, and with which value. A Search ROM step for one identifier bit takes three slots. In the first the device sends the true bit, in the second it sends the complement, and in the third it reads the master's chosen direction. A Match ROM that succeeds raises a selected status and returns to reading a command byte, so that a device-specific command can follow.

Top module: `onewire_rom_ctl`

## Requirements
- R1: While rst_ni is low, idle_o is 1, selected_o is 0 and tx_en_o is 0.
- R2: A cycle with bus_reset_i high puts the block into command reading, with idle_o 0, selected_o 0 and tx_en_o 0 from the next cycle. This happens even when slot_i is high in the same cycle, and the partial command count is discarded.
- R3: In command reading, the line_i values of 8 slot_i strobes form a byte, the first slot giving bit 0. The byte 0x55 starts a match and the byte 0xF0 starts a search. Any other value sets idle_o on the cycle after the eighth strobe.
- R4: In a match, slot k (k = 0..63) is compared with bit k of DEV_ID, where bit k is bit k mod 8 of identifier byte k/8. The default identifier bytes, from byte 0 up, are 1D A2 D9 84 02 00 00 C4. When all 64 slots agree, selected_o rises after the last slot and the block reads a new command byte.
- R5: A match slot whose line_i differs from the identifier bit sets idle_o and keeps selected_o at 0.
- R6: In a search, each identifier bit k takes three slots. Before the first slot, tx_en_o is 1 and tx_bit_o equals ID bit k. Before the second slot, tx_en_o is 1 and tx_bit_o is the inverse of that bit. Before the third slot, tx_en_o is 0.
- R7: In the third slot of a search step, a line_i that differs from ID bit k sets idle_o. After the third slot of bit 63, idle_o is also set.
- R8: While idle_o is 1, slot strobes change nothing: idle_o stays 1 and tx_en_o and selected_o stay 0 until bus_reset_i.
- R9: After a successful match, selected_o stays 1 while the next command byte is read. A following 0xF0 clears selected_o and starts a search. An unknown byte clears selected_o and sets idle_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_reset_i | input | 1 | One-cycle strobe: reset and presence sequence finished |
| slot_i | input | 1 | One-cycle strobe: a time slot has ended |
| line_i | input | 1 | Line value sampled in the slot that just ended |
| tx_en_o | output | 1 | The device drives the next slot |
| tx_bit_o | output | 1 | Bit to send in the next slot when tx_en_o is 1 |
| selected_o | output | 1 | Device selected by Match ROM, waiting for a command |
| idle_o | output | 1 | Device parked until the next bus reset |

## Verification
The bus reset strobe and the end-of-slot strobe can arrive in the same cycle. The bench provokes this by raising both strobes together partway through a match. It then checks that the block is reading a command rather than treating the strobe as a match slot. It also checks that a complete 0x55 command and a full correct identifier still lead to selection, which shows that the interrupted command and bit counts were discarded. Along the same lines, the third-slot comparison of a search is judged against a deliberately wrong master choice, and against the final bit 63.

// File: rtl/onewire_rom_pkg.sv
package onewire_rom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_MATCH,
    ST_SEARCH
  } rom_state_e;

  typedef enum logic [1:0] {
    PH_TRUE,
    PH_COMP,
    PH_READ
  } srch_phase_e;

endpackage

// File: rtl/onewire_rom_cmd_rx.sv
module onewire_rom_cmd_rx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic [W-2:0]  sr_q;

  // lsb arrives first, so shift right
  assign byte_o = {bit_i, sr_q};
  assign done_o = shift_i && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sr_q  <= byte_o[W-1:1];
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/onewire_rom_bit_ctr.sv
module onewire_rom_bit_ctr
  import onewire_rom_pkg::*;
#(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          triple_i,
  output logic [IW-1:0] idx_o,
  output srch_phase_e   phase_o,
  output logic          last_o
);
  logic [IW-1:0] idx_q;
  srch_phase_e   ph_q;
  logic          step;

  // in triple mode the index moves only after the read phase
  assign step    = adv_i && (!triple_i || ph_q == PH_READ);
  assign idx_o   = idx_q;
  assign phase_o = ph_q;
  assign last_o  = (idx_q == IW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_TRUE;
    end else if (clr_i) begin
      idx_q <= '0;
      ph_q  <= PH_TRUE;
    end else if (adv_i) begin
      if (step) idx_q <= idx_q + 1'b1;
      if (triple_i) begin
        unique case (ph_q)
          PH_TRUE: ph_q <= PH_COMP;
          PH_COMP: ph_q <= PH_READ;
          default: ph_q <= PH_TRUE;
        endcase
      end
    end
  end
endmodule

// File: rtl/onewire_rom_id_sel.sv
module onewire_rom_id_sel #(
  parameter int          N  = 64,
  parameter logic [N-1:0] ID = '0,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0] idx_i,
  output logic          bit_o
);
  logic [N-1:0] id_vec;

  for (genvar g = 0; g < N; g++) begin : g_id
    assign id_vec[g] = ID[g];
  end

  assign bit_o = id_vec[idx_i];
endmodule

// File: rtl/onewire_rom_ctl.sv
module onewire_rom_ctl
  import onewire_rom_pkg::*;
#(
  parameter int              ID_BITS    = 64,
  parameter int              CMD_BITS   = 8,
  parameter logic [ID_BITS-1:0] DEV_ID  = 64'hC400_0002_84D9_A21D,
  parameter logic [CMD_BITS-1:0] CMD_MATCH  = 8'h55,
  parameter logic [CMD_BITS-1:0] CMD_SEARCH = 8'hF0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic slot_i,
  input  logic line_i,
  output logic tx_en_o,
  output logic tx_bit_o,
  output logic selected_o,
  output logic idle_o
);
  localparam int IW = $clog2(ID_BITS);

  rom_state_e          st_q, st_n;
  logic                matched_q, matched_n;
  logic                slot_ok;
  logic                cmd_done;
  logic [CMD_BITS-1:0] cmd_byte;
  logic [IW-1:0]       bit_idx;
  srch_phase_e         phase;
  logic                last_bit;
  logic                id_bit;

  // bus reset outranks a slot strobe in the same cycle
  assign slot_ok = slot_i && !bus_reset_i;

  onewire_rom_cmd_rx #(.W(CMD_BITS)) u_cmd_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bus_reset_i),
    .shift_i(slot_ok && st_q == ST_CMD),
    .bit_i  (line_i),
    .done_o (cmd_done),
    .byte_o (cmd_byte)
  );

  onewire_rom_bit_ctr #(.N(ID_BITS)) u_bit_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bus_reset_i || st_q == ST_CMD),
    .adv_i   (slot_ok && (st_q == ST_MATCH || st_q == ST_SEARCH)),
    .triple_i(st_q == ST_SEARCH),
    .idx_o   (bit_idx),
    .phase_o (phase),
    .last_o  (last_bit)
  );

  onewire_rom_id_sel #(.N(ID_BITS), .ID(DEV_ID)) u_id_sel (
    .idx_i(bit_idx),
    .bit_o(id_bit)
  );

  always_comb begin
    st_n      = st_q;
    matched_n = matched_q;
    if (bus_reset_i) begin
      st_n      = ST_CMD;
      matched_n = 1'b0;
    end else if (slot_i) begin
      unique case (st_q)
        ST_CMD: begin
          if (cmd_done) begin
            matched_n = 1'b0;
            if (cmd_byte == CMD_MATCH)       st_n = ST_MATCH;
            else if (cmd_byte == CMD_SEARCH) st_n = ST_SEARCH;
            else                             st_n = ST_IDLE;
          end
        end
        ST_MATCH: begin
          if (line_i != id_bit) begin
            st_n = ST_IDLE;
          end else if (last_bit) begin
            st_n      = ST_CMD;
            matched_n = 1'b1;
          end
        end
        ST_SEARCH: begin
          if (phase == PH_READ && (line_i != id_bit || last_bit)) st_n = ST_IDLE;
        end
        default: st_n = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      matched_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      matched_q <= matched_n;
    end
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign selected_o = matched_q && (st_q == ST_CMD);
  assign tx_en_o    = (st_q == ST_SEARCH) && (phase != PH_READ);
  assign tx_bit_o   = (phase == PH_TRUE) ? id_bit : !id_bit;
endmodule

// File: rtl/onewire_rom_chk.sv
module onewire_rom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_reset_i,
  input logic slot_i,
  input logic line_i,
  input logic tx_en_o,
  input logic tx_bit_o,
  input logic selected_o,
  input logic idle_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (idle_o && !selected_o && !tx_en_o)
        else $error("reset state wrong");
    end
  end

  p_bus_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !idle_o && !selected_o && !tx_en_o);

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && !bus_reset_i |=> idle_o && !tx_en_o && !selected_o);

  p_tx_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> !idle_o && !selected_o);

  p_sel_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o |-> !idle_o && !tx_en_o);

  p_sel_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selected_o && !slot_i && !bus_reset_i |=> selected_o);

  p_line_unused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i && !bus_reset_i |=> $stable(idle_o) && $stable(selected_o) && $stable(tx_en_o));
endmodule

bind onewire_rom_ctl onewire_rom_chk u_chk (.*);

// File: tb/onewire_rom_ctl_bench.sv
module onewire_rom_ctl_bench;
  localparam logic [63:0] ID = 64'hC400_0002_84D9_A21D;

  typedef struct {
    string tag;
    bit    idle;
    bit    sel;
    bit    txen;
    bit    txbit;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic bus_reset = 1'b0;
  logic slot = 1'b0;
  logic line = 1'b1;
  logic tx_en, tx_bit, selected, idle;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  event item_ev;

  always #4 clk = ~clk;

  onewire_rom_ctl #(.DEV_ID(ID)) u_onewire_rom_ctl (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .bus_reset_i(bus_reset),
    .slot_i     (slot),
    .line_i     (line),
    .tx_en_o    (tx_en),
    .tx_bit_o   (tx_bit),
    .selected_o (selected),
    .idle_o     (idle)
  );

  task automatic cmp(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  // monitor: pops expectations as the driver announces them
  initial begin
    forever begin
      @(item_ev);
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        cmp(it.tag, "idle_o", idle, it.idle);
        cmp(it.tag, "selected_o", selected, it.sel);
        cmp(it.tag, "tx_en_o", tx_en, it.txen);
        if (it.txen) cmp(it.tag, "tx_bit_o", tx_bit, it.txbit);
      end
    end
  end

  task automatic push(input string tag, input bit e_idle, input bit e_sel,
                      input bit e_txen, input bit e_txbit);
    exp_t it;
    it.tag = tag; it.idle = e_idle; it.sel = e_sel; it.txen = e_txen; it.txbit = e_txbit;
    q.push_back(it);
    ->item_ev;
  endtask

  task automatic do_slot(input bit b, input string tag, input bit e_idle, input bit e_sel,
                         input bit e_txen, input bit e_txbit);
    @(negedge clk);
    slot = 1'b1; line = b;
    @(negedge clk);
    slot = 1'b0; line = 1'b1;
    push(tag, e_idle, e_sel, e_txen, e_txbit);
  endtask

  task automatic do_bus_reset(input bit with_slot);
    @(negedge clk);
    bus_reset = 1'b1; slot = with_slot; line = 1'b0;
    @(negedge clk);
    bus_reset = 1'b0; slot = 1'b0; line = 1'b1;
    push("R2", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic send_cmd(input logic [7:0] c, input bit sel_before);
    for (int i = 0; i < 8; i++) begin
      if (i < 7) do_slot(c[i], "R3", 1'b0, sel_before, 1'b0, 1'b0);
      else if (c == 8'h55) do_slot(c[i], "R3", 1'b0, 1'b0, 1'b0, 1'b0);
      else if (c == 8'hF0) do_slot(c[i], "R9", 1'b0, 1'b0, 1'b1, ID[0]);
      else do_slot(c[i], "R3", 1'b1, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic send_match(input logic [63:0] v);
    bit failed = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (failed) do_slot(v[i], "R8", 1'b1, 1'b0, 1'b0, 1'b0);
      else if (v[i] != ID[i]) begin
        failed = 1'b1;
        do_slot(v[i], "R5", 1'b1, 1'b0, 1'b0, 1'b0);
      end else if (i == 63) do_slot(v[i], "R4", 1'b0, 1'b1, 1'b0, 1'b0);
      else do_slot(v[i], "R4", 1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic run_search(input logic [63:0] choose);
    bit failed = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (failed) begin
        for (int k = 0; k < 3; k++) do_slot(choose[i], "R8", 1'b1, 1'b0, 1'b0, 1'b0);
      end else begin
        do_slot(ID[i], "R6", 1'b0, 1'b0, 1'b1, !ID[i]);
        do_slot(1'b0, "R6", 1'b0, 1'b0, 1'b0, 1'b0);
        if (choose[i] != ID[i]) begin
          failed = 1'b1;
          do_slot(choose[i], "R7", 1'b1, 1'b0, 1'b0, 1'b0);
        end else if (i == 63) do_slot(choose[i], "R7", 1'b1, 1'b0, 1'b0, 1'b0);
        else do_slot(choose[i], "R6", 1'b0, 1'b0, 1'b1, ID[i+1]);
      end
    end
  endtask

  task automatic idle_slots(input logic [7:0] pat);
    for (int i = 0; i < 8; i++) do_slot(pat[i], "R8", 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  bit done = 1'b0;

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    push("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    push("R1", 1'b1, 1'b0, 1'b0, 1'b0);

    // slots before any bus reset are ignored
    idle_slots(8'h55);

    // exact match, then search from the selected state
    do_bus_reset(1'b0);
    send_cmd(8'h55, 1'b0);
    send_match(ID);
    repeat (3) @(negedge clk);
    push("R9", 1'b0, 1'b1, 1'b0, 1'b0);
    send_cmd(8'hF0, 1'b1);
    run_search(ID);
    idle_slots(8'hF0);

    // match with one wrong bit
    do_bus_reset(1'b0);
    send_cmd(8'h55, 1'b0);
    send_match(ID ^ (64'd1 << 37));

    // search with a diverging master choice
    do_bus_reset(1'b0);
    send_cmd(8'hF0, 1'b0);
    run_search(ID ^ (64'd1 << 10));

    // unknown command
    do_bus_reset(1'b0);
    send_cmd(8'hCC, 1'b0);
    idle_slots(8'h0F);

    // unknown command after selection
    do_bus_reset(1'b0);
    send_cmd(8'h55, 1'b0);
    send_match(ID);
    send_cmd(8'h33, 1'b1);
    idle_slots(8'hA5);

    // bus reset coinciding with a slot mid-match, partial command too
    do_bus_reset(1'b0);
    send_cmd(8'h55, 1'b0);
    for (int i = 0; i < 20; i++) do_slot(ID[i], "R4", 1'b0, 1'b0, 1'b0, 1'b0);
    do_bus_reset(1'b1);
    for (int i = 0; i < 3; i++) do_slot(1'b1, "R3", 1'b0, 1'b0, 1'b0, 1'b0);
    do_bus_reset(1'b1);
    send_cmd(8'h55, 1'b0);
    send_match(ID);

    repeat (4) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule